// File: doc/BRIEF.md
# Memory Module Presence-Detect Reader

This block identifies the memory module fitted in a slot by reading the module's static identification pins. The presence-detect outputs on such a module drive only while an active-low enable is held low. At all other times they float, and board pull-ups read them as ones. A single request pulse starts one read sequence:

1. The reader pulls the enable low.
2. It waits long enough for the pins to settle and for its input synchronizers to fill.
3. It captures eight presence-detect bits and two ID bits.
4. It releases the enable.
5. It waits out the turn-off window.
6. It publishes the result with a one-cycle done pulse.

The result gives a presence flag, a module class (fast grade, slow grade, unknown, or none) and the raw ten-bit code. The result holds until the next completed read. Timing is set in picoseconds through parameters. The block converts it to clock cycles, rounding up, so a clock-frequency change needs only one parameter update.

Top module: `mod_id_reader`

## Requirements
- R1: After reset, `pd_en_n` is 1, `done` is 0, `mod_kind` is 0 (none), `mod_present` is 0 and `raw_code` is 0.
- R2: A `req` pulse while idle drives `pd_en_n` low for exactly SETTLE+SYNC_STAGES cycles. SETTLE is ceil(SETTLE_PS/CLK_PS) cycles, with a minimum of 2.
- R3: After `pd_en_n` returns high, it stays high for REL cycles, and then `done` pulses high for exactly one cycle. REL is ceil(RELEASE_PS/CLK_PS) cycles, with a minimum of 1.
- R4: A captured pattern `pd_pins`=8'hE4 (bit 0 is the first presence pin) with `id_pins`=2'b00 gives `mod_kind`=1 (fast grade) and `mod_present`=1.
- R5: A captured pattern `pd_pins`=8'hC4 with `id_pins`=2'b00 gives `mod_kind`=2 (slow grade) and `mod_present`=1.
- R6: A captured `pd_pins` value of all ones gives `mod_kind`=0 (none) and `mod_present`=0, whatever the ID bits are.
- R7: Any other captured pattern gives `mod_kind`=3 (unknown) and `mod_present`=1. This includes a known pattern with nonzero `id_pins`.
- R8: `raw_code` is {id_pins, pd_pins} as captured during the enable-low window.
- R9: A `req` that arrives while a sequence is running is ignored. It produces no extra done pulse and does not lengthen the enable-low time.
- R10: `mod_kind`, `mod_present` and `raw_code` change only in the cycle where `done` is high.
- R11: Pin activity while `pd_en_n` is high, including the turn-off window, has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start pulse for one read sequence |
| pd_pins | input | PD_W | Presence-detect pins (asynchronous) |
| id_pins | input | ID_W | ID pins (asynchronous) |
| pd_en_n | output | 1 | Active-low enable to the module's presence-detect drivers |
| done | output | 1 | One-cycle pulse marking a new result |
| mod_present | output | 1 | A module was detected |
| mod_kind | output | 2 | 0 none, 1 fast grade, 2 slow grade, 3 unknown |
| raw_code | output | ID_W+PD_W | Captured {ID, presence-detect} bits |

## Verification
The bench builds the reader with a 20 ns clock, SETTLE_PS=75000 and RELEASE_PS=30000. These values give a settle time of four cycles, which is above the two-cycle minimum, and a release window of two cycles. That combination exercises the round-up conversion and a multi-cycle ignore window, which the default single-cycle release never reaches. The pin model drives changing noise whenever the enable is high, so a capture taken at the wrong moment shows up as a wrong raw code.

// File: rtl/mod_id_pkg.sv
package mod_id_pkg;
   typedef enum logic [1:0] {
      MOD_NONE    = 2'd0,
      MOD_FAST    = 2'd1,
      MOD_SLOW    = 2'd2,
      MOD_UNKNOWN = 2'd3
   } mod_kind_e;

   function automatic int cyc_ceil(input int span_ps, input int clk_ps, input int floor_cyc);
      int c;
      c = (span_ps + clk_ps - 1) / clk_ps;
      return (c < floor_cyc) ? floor_cyc : c;
   endfunction
endpackage

// File: rtl/mod_id_sync.sv
module mod_id_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("mod_id_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '1;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '1;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mod_id_decode.sv
module mod_id_decode
   import mod_id_pkg::*;
#(
   parameter int             PD_W     = 8,
   parameter int             ID_W     = 2,
   parameter logic [PD_W-1:0] PAT_FAST = 8'hE4,
   parameter logic [PD_W-1:0] PAT_SLOW = 8'hC4
) (
   input  logic [PD_W-1:0] pd,
   input  logic [ID_W-1:0] id,
   output mod_kind_e       kind,
   output logic            present
);
   if (PAT_FAST == PAT_SLOW) begin : g_bad
      $error("mod_id_decode: grade patterns must differ");
   end

   always_comb begin
      if (&pd)                                kind = MOD_NONE;
      else if (id == '0 && pd == PAT_FAST)    kind = MOD_FAST;
      else if (id == '0 && pd == PAT_SLOW)    kind = MOD_SLOW;
      else                                    kind = MOD_UNKNOWN;
      present = ~(&pd);
   end
endmodule

// File: rtl/mod_id_seq.sv
module mod_id_seq #(
   parameter int WAIT_CYC = 4,
   parameter int REL_CYC  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pd_en_n,
   output logic cap_en,
   output logic upd_en,
   output logic done
);
   localparam int CMAX  = (WAIT_CYC > REL_CYC) ? WAIT_CYC : REL_CYC;
   localparam int CNT_W = $clog2(CMAX + 1);

   typedef enum logic [1:0] {S_IDLE, S_LOW, S_REL} st_e;
   st_e             st;
   logic [CNT_W-1:0] cnt;

   assign cap_en = (st == S_LOW) && (cnt == CNT_W'(WAIT_CYC - 1));
   assign upd_en = (st == S_REL) && (cnt == CNT_W'(REL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cnt     <= '0;
         pd_en_n <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (req) begin
               st      <= S_LOW;
               cnt     <= '0;
               pd_en_n <= 1'b0;
            end
            S_LOW: if (cap_en) begin
               st      <= S_REL;
               cnt     <= '0;
               pd_en_n <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
            S_REL: if (upd_en) begin
               st   <= S_IDLE;
               cnt  <= '0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R3: done lasts one cycle
   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: the enable is never a single-cycle glitch
   p_enable_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_en_n) |=> !pd_en_n);
   // R3: done only follows a released enable
   p_done_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pd_en_n && $past(pd_en_n)));
endmodule

// File: rtl/mod_id_reader.sv
module mod_id_reader
   import mod_id_pkg::*;
#(
   parameter int              PD_W        = 8,
   parameter int              ID_W        = 2,
   parameter int              SYNC_STAGES = 2,
   parameter int              CLK_PS      = 20000,
   parameter int              SETTLE_PS   = 10000,
   parameter int              RELEASE_PS  = 10000,
   parameter logic [PD_W-1:0] PAT_FAST    = 8'hE4,
   parameter logic [PD_W-1:0] PAT_SLOW    = 8'hC4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [PD_W-1:0]    pd_pins,
   input  logic [ID_W-1:0]    id_pins,
   output logic               pd_en_n,
   output logic               done,
   output logic               mod_present,
   output logic [1:0]         mod_kind,
   output logic [ID_W+PD_W-1:0] raw_code
);
   localparam int SETTLE_CYC = cyc_ceil(SETTLE_PS, CLK_PS, 2);
   localparam int REL_CYC    = cyc_ceil(RELEASE_PS, CLK_PS, 1);
   localparam int WAIT_CYC   = SETTLE_CYC + SYNC_STAGES;
   localparam int RAW_W      = ID_W + PD_W;

   if (CLK_PS <= 0 || PD_W < 1 || ID_W < 1) begin : g_bad
      $error("mod_id_reader: bad parameter");
   end

   logic [RAW_W-1:0] sync_q, cap_q;
   logic             cap_en, upd_en;
   mod_kind_e        dec_kind;
   logic             dec_present;

   mod_id_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({id_pins, pd_pins}), .q(sync_q));

   mod_id_seq #(.WAIT_CYC(WAIT_CYC), .REL_CYC(REL_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .pd_en_n(pd_en_n),
      .cap_en(cap_en), .upd_en(upd_en), .done(done));

   mod_id_decode #(.PD_W(PD_W), .ID_W(ID_W), .PAT_FAST(PAT_FAST), .PAT_SLOW(PAT_SLOW)) u_dec (
      .pd(cap_q[PD_W-1:0]), .id(cap_q[RAW_W-1:PD_W]),
      .kind(dec_kind), .present(dec_present));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q       <= '0;
         mod_kind    <= MOD_NONE;
         mod_present <= 1'b0;
         raw_code    <= '0;
      end else begin
         if (cap_en) cap_q <= sync_q;
         if (upd_en) begin
            mod_kind    <= dec_kind;
            mod_present <= dec_present;
            raw_code    <= cap_q;
         end
      end
   end

   // R10: result holds outside the done cycle
   p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(mod_kind) && $stable(raw_code) && $stable(mod_present)));
   // R6: presence flag agrees with the class
   p_present_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mod_present == (mod_kind != MOD_NONE));
endmodule

// File: tb/tb_mod_id_reader.sv
module tb_mod_id_reader;
   localparam int E_WAIT = 6;  // 75 ns / 20 ns rounded up = 4, plus 2 sync stages
   localparam int E_REL  = 2;  // 30 ns / 20 ns rounded up

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic [7:0] pat = 8'hFF;
   logic [1:0] idv = 2'b00;
   logic [7:0] noise = 8'h00;
   logic [7:0] pd_pins;
   logic [1:0] id_pins;
   logic       pd_en_n, done, mod_present;
   logic [1:0] mod_kind;
   logic [9:0] raw_code;

   int n_chk = 0, n_fail = 0, n_push = 0, n_done = 0, cyc = 0;
   int exp_kind_q[$];
   logic [9:0] exp_raw_q[$];

   always #10 clk = ~clk;

   // module pins: drive only while enabled, otherwise arbitrary (R11)
   assign pd_pins = pd_en_n ? noise : pat;
   assign id_pins = pd_en_n ? noise[1:0] : idv;

   mod_id_reader #(.CLK_PS(20000), .SETTLE_PS(75000), .RELEASE_PS(30000)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .pd_pins(pd_pins), .id_pins(id_pins),
      .pd_en_n(pd_en_n), .done(done), .mod_present(mod_present),
      .mod_kind(mod_kind), .raw_code(raw_code));

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int exp_kind(input logic [7:0] p, input logic [1:0] i);
      if (p == 8'hFF) return 0;                 // R6
      if (i == 2'b00 && p == 8'hE4) return 1;   // R4
      if (i == 2'b00 && p == 8'hC4) return 2;   // R5
      return 3;                                 // R7
   endfunction

   // driver: pushes expected result, then runs one sequence
   task automatic run_read(input logic [7:0] p, input logic [1:0] i, input bit poke);
      exp_kind_q.push_back(exp_kind(p, i));
      exp_raw_q.push_back({i, p});
      n_push++;
      @(negedge clk);
      pat = p; idv = i; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      if (poke) begin           // R9: request while busy
         @(negedge clk); req = 1'b1;
         @(negedge clk); req = 1'b0;
      end
      repeat (E_WAIT + E_REL + 3) @(negedge clk);
   endtask

   // monitor / scoreboard
   logic       prev_en = 1'b1;
   int         low_cnt = 0, rel_cnt = 0;
   bit         rel_on = 0, hold_bad = 0;
   logic [1:0] last_kind = 2'd0;
   logic [9:0] last_raw = '0;

   always @(negedge clk) begin
      noise <= noise + 8'h3B;
      if (rst_n) begin
         if (!pd_en_n) low_cnt++;
         if (!prev_en && pd_en_n) begin
            chk(low_cnt == E_WAIT, "R2", "enable low cycles", low_cnt, E_WAIT);
            low_cnt = 0; rel_cnt = 0; rel_on = 1;
         end
         if (done) begin
            n_done++;
            chk(rel_on && rel_cnt == E_REL, "R3", "release cycles before done", rel_cnt, E_REL);
            rel_on = 0;
            chk(!hold_bad, "R10", "result moved between dones", 1, 0);
            hold_bad = 0;
            if (exp_kind_q.size() == 0) begin
               chk(0, "R9", "unexpected done", 1, 0);
            end else begin
               automatic int         ek = exp_kind_q.pop_front();
               automatic logic [9:0] er = exp_raw_q.pop_front();
               chk(mod_kind == 2'(ek), (ek == 0) ? "R6" : (ek == 3) ? "R7" : "R4/R5",
                   "kind", mod_kind, ek);
               chk(mod_present == (ek != 0), "R6", "present", mod_present, ek != 0);
               chk(raw_code == er, "R8 R11", "raw code", raw_code, er);
            end
            last_kind = mod_kind; last_raw = raw_code;
         end else begin
            if (rel_on && pd_en_n) rel_cnt++;
            if (mod_kind != last_kind || raw_code != last_raw) hold_bad = 1;
         end
         prev_en = pd_en_n;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(pd_en_n == 1'b1 && done == 1'b0, "R1", "enable/done at reset", {pd_en_n, done}, 2'b10);
      chk(mod_kind == 2'd0 && mod_present == 1'b0 && raw_code == '0, "R1", "result at reset",
          {mod_kind, mod_present, raw_code}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_read(8'hE4, 2'b00, 0);   // R4
      run_read(8'hC4, 2'b00, 0);   // R5
      run_read(8'hFF, 2'b00, 0);   // R6
      run_read(8'hFF, 2'b10, 0);   // R6 with ID bits set
      run_read(8'h5A, 2'b00, 0);   // R7
      run_read(8'hE4, 2'b01, 0);   // R7 known pattern, wrong ID
      run_read(8'hC4, 2'b00, 1);   // R9 busy request
      run_read(8'h00, 2'b11, 1);   // R7, R8, R9
      repeat (12) @(negedge clk);
      chk(n_done == n_push, "R9", "done count", n_done, n_push);
      chk(mod_kind == 2'd3 && raw_code == 10'h300, "R10", "final result held",
          {mod_kind, raw_code}, {2'd3, 10'h300});
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      while (cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      chk(0, "watchdog", "timeout", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule